// File: doc/BRIEF.md
# Two-Level Serial Majority Voter

This block sits in a clock-data-recovery loop. It watches a serial stream of phase decisions (early, late or no-decision) and turns every four consecutive valid decisions into one majority verdict. The aim is to slow the rate at which the loop corrects its phase and to suppress isolated wrong decisions.

The verdict is not produced by counting. Two pairwise vote stages are chained. The first stage reduces each pair of decisions to the sign of their sum. The second stage reduces each pair of first-stage results the same way. Each stage needs only one phase toggle flop, a one-decision holding register and a few gates. The result register is written only when the verdict actually changes, which keeps switching on the output low.

Each decision enters on two wires, `dec_up` and `dec_dn`, qualified by `dec_valid`. The verdict leaves on `vote_up` and `vote_dn`. `vote_valid` pulses once per completed group. Between pulses the verdict wires keep the last result.

Top module: `serial_vote4`

## Requirements
- R1: While `rst_n` is sampled low and on the first cycle after it, `vote_valid` is 0 and `{vote_up, vote_dn}` is 2'b00.
- R2: Every fourth valid decision completes a group. `vote_valid` is high for exactly one cycle, in the cycle right after the clock edge that captures that fourth decision, and is low at all other times.
- R3: Pairwise rule, with up = +1, down = -1 and hold = 0: the pair result is the sign of the sum. Two equal values give that value, hold with X gives X, and up with down gives hold.
- R4: A group d1..d4 votes as pair(pair(d1,d2), pair(d3,d4)). Examples: a 2-2 up/down split gives hold, a 3-1 split gives the majority, two up plus two hold gives up, and up,down,up,hold gives up.
- R5: Input coding is {dec_up, dec_dn}: 2'b10 = up, 2'b01 = down, 2'b00 = hold. The code 2'b11 counts as hold.
- R6: The output `{vote_up, vote_dn}` uses the same coding and is never 2'b11.
- R7: A cycle with `dec_valid` low does not count toward a group and does not contribute to any vote.
- R8: `{vote_up, vote_dn}` changes only in a cycle where `vote_valid` is high. It holds its value otherwise.
- R9: Grouping starts at the first valid decision after reset. A reset in the middle of a group discards the partial group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decision on dec_up/dec_dn is valid this cycle |
| dec_up | input | 1 | Decision says up (late) |
| dec_dn | input | 1 | Decision says down (early) |
| vote_valid | output | 1 | One-cycle pulse per completed group |
| vote_up | output | 1 | Verdict is up |
| vote_dn | output | 1 | Verdict is down |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any checked cycle. They also assume that `dec_valid` is a plain synchronous qualifier with no meaning beyond counting, so a checker-side modulo-four count of valid inputs can predict each pulse. The bench keeps to these assumptions: it holds reset for several cycles and drives every input on the falling edge. Its stimulus mixes back-to-back decisions, decisions with idle gaps, the 2'b11 code and a mid-group reset. Each of these cases stays inside what the reference model defines.

// File: rtl/vote_pkg.sv
// Shared ternary type and the pairwise sign-of-sum rule.
// Assumes the two-wire coding: 10 = up, 01 = down, 00 = hold.
package vote_pkg;

    typedef enum logic [1:0] {
        T_HOLD = 2'b00,
        T_DN   = 2'b01,
        T_UP   = 2'b10
    } tern_t;

    // Map a raw two-wire decision to a legal ternary value; 11 folds to hold.
    function automatic tern_t decode_dec(input logic up, input logic dn);
        if (up && !dn)      return T_UP;
        else if (dn && !up) return T_DN;
        else                return T_HOLD;
    endfunction

    // Sign of the sum of two ternary values.
    function automatic tern_t pair_sign(input tern_t a, input tern_t b);
        if (a == b)           return a;
        else if (a == T_HOLD) return b;
        else if (b == T_HOLD) return a;
        else                  return T_HOLD;
    endfunction

endpackage

// File: rtl/pair_vote_stage.sv
// One pairwise vote stage. It stores the first value of each pair and,
// when the second value arrives, presents the sign of the pair sum
// combinationally with a one-cycle valid.
// Assumes in_vote is already a legal ternary value.
module pair_vote_stage
    import vote_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  tern_t in_vote,
    output logic  out_valid,
    output tern_t out_vote
);

    logic  phase_q;   // 1 = first value of the pair is held
    tern_t held_q;

    // Toggle the pair phase on each valid value; capture only the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            held_q  <= T_HOLD;
        end else if (in_valid) begin
            phase_q <= ~phase_q;
            if (!phase_q) held_q <= in_vote;
        end
    end

    // Emit the pair result while the second value is present.
    always_comb begin
        out_valid = in_valid & phase_q;
        out_vote  = pair_sign(held_q, in_vote);
    end

endmodule

// File: rtl/vote_hold_reg.sv
// Output register. The verdict flops are written only when a new result
// differs from the stored one, which keeps output toggling low.
// The valid flop is a single-cycle pulse.
// Assumes in_valid is never high on two consecutive cycles.
module vote_hold_reg
    import vote_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  tern_t in_vote,
    output logic  out_valid,
    output tern_t out_vote
);

    tern_t vote_q;
    logic  valid_q;

    // Register the pulse each cycle; rewrite the verdict only on a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vote_q  <= T_HOLD;
        end else begin
            valid_q <= in_valid;
            if (in_valid && (in_vote != vote_q)) vote_q <= in_vote;
        end
    end

    // Drive the outputs straight from the flops.
    always_comb begin
        out_valid = valid_q;
        out_vote  = vote_q;
    end

endmodule

// File: rtl/serial_vote4.sv
// Serial majority voter built from a chain of ORDER pairwise stages.
// It gives one verdict per 2**ORDER valid decisions, one clock after the
// last decision of the group. Assumes synchronous inputs.
module serial_vote4
    import vote_pkg::*;
#(
    parameter int ORDER = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_up,
    input  logic dec_dn,
    output logic vote_valid,
    output logic vote_up,
    output logic vote_dn
);

    localparam int GROUP_LEN = 1 << ORDER;

    logic  lvl_valid [ORDER+1];
    tern_t lvl_vote  [ORDER+1];
    tern_t final_vote;

    // Fold the raw decision into a legal ternary value at the chain input.
    always_comb begin
        lvl_valid[0] = dec_valid;
        lvl_vote[0]  = decode_dec(dec_up, dec_dn);
    end

    // Build the cascade of pairwise vote stages.
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        pair_vote_stage u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lvl_valid[g]),
            .in_vote   (lvl_vote[g]),
            .out_valid (lvl_valid[g+1]),
            .out_vote  (lvl_vote[g+1])
        );
    end

    vote_hold_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lvl_valid[ORDER]),
        .in_vote   (lvl_vote[ORDER]),
        .out_valid (vote_valid),
        .out_vote  (final_vote)
    );

    // Split the verdict onto the two output wires.
    always_comb begin
        {vote_up, vote_dn} = final_vote;
    end

endmodule

// File: rtl/serial_vote4_chk.sv
// Property checker for serial_vote4. It counts valid decisions on its own
// to predict each verdict pulse. Assumes reset is held for at least one edge.
module serial_vote4_chk #(
    parameter int GROUP_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic dec_valid,
    input logic vote_valid,
    input logic vote_up,
    input logic vote_dn
);

    localparam int CW = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1;

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          last_in;

    assign last_in = dec_valid && (cnt_q == CW'(GROUP_LEN - 1));

    // Count valid decisions modulo the group length; arm after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (dec_valid) cnt_q <= last_in ? '0 : cnt_q + 1'b1;
        end
    end

    p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(vote_up && vote_dn));

    p_pulse_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_in |=> vote_valid);

    p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && vote_valid) |-> $past(last_in));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vote_valid |=> !vote_valid);

    p_vote_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !vote_valid) |-> $stable({vote_up, vote_dn}));

endmodule

bind serial_vote4 serial_vote4_chk #(.GROUP_LEN(1 << ORDER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .vote_valid (vote_valid),
    .vote_up    (vote_up),
    .vote_dn    (vote_dn)
);

// File: tb/serial_vote4_tb.sv
module serial_vote4_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic dec_up = 1'b0;
    logic dec_dn = 1'b0;
    logic vote_valid, vote_up, vote_dn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int grp[$];
    int exp_vote  = 0;
    bit exp_valid = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    serial_vote4 u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_up(dec_up), .dec_dn(dec_dn),
        .vote_valid(vote_valid), .vote_up(vote_up), .vote_dn(vote_dn)
    );

    function automatic int sgn(input int x);
        return (x > 0) ? 1 : (x < 0) ? -1 : 0;
    endfunction

    function automatic int code_of(input bit u, input bit d);
        return (u && !d) ? 1 : (d && !u) ? -1 : 0;
    endfunction

    function automatic int pins_val();
        if (vote_up && vote_dn) return 2;
        return code_of(vote_up, vote_dn);
    endfunction

    task automatic check_now();
        n_checks++;
        if (vote_valid !== exp_valid || pins_val() != exp_vote) begin
            n_fail++;
            $display("FAIL %s: valid=%0b vote=%0d expected valid=%0b vote=%0d",
                     tag, vote_valid, pins_val(), exp_valid, exp_vote);
        end
    endtask

    // One clock: drive at the falling edge, model the posedge, check at the next falling edge.
    task automatic step(input bit v, input bit u, input bit d);
        dec_valid = v; dec_up = u; dec_dn = d;
        exp_valid = 1'b0;
        if (v) begin
            grp.push_back(code_of(u, d));
            if (grp.size() == 4) begin
                exp_vote  = sgn(sgn(grp[0] + grp[1]) + sgn(grp[2] + grp[3]));
                exp_valid = 1'b1;
                grp.delete();
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_now();
    endtask

    // Drive one decision given as +1 / -1 / 0.
    task automatic put(input int x);
        step(1'b1, x > 0, x < 0);
    endtask

    task automatic group4(input int a, input int b, input int c, input int e);
        put(a); put(b); put(c); put(e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dec_valid = 1'b0;
        grp.delete(); exp_vote = 0; exp_valid = 1'b0;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            tag = "R1"; check_now();
        end
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        tag = "R1"; step(1'b0, 1'b0, 1'b0);

        // R3: the pairwise rule seen through groups
        tag = "R3";
        group4( 1,  1,  0,  0);   // up
        group4( 0,  0, -1,  0);   // down
        group4( 1, -1,  0,  0);   // hold
        group4(-1, -1, -1, -1);   // down

        // R4: cascade examples
        tag = "R4";
        group4( 1,  1, -1, -1);   // 2-2 split -> hold
        group4(-1, -1, -1,  1);   // 3-1 -> down
        group4( 1,  0,  1,  0);   // two up two hold -> up
        group4( 1, -1,  1,  0);   // -> up
        group4( 1, -1, -1,  1);   // -> hold

        // R5: code 11 counts as hold
        tag = "R5";
        put(1); step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1); put(0);   // up
        put(-1); step(1'b1, 1'b1, 1'b1); put(1); put(0);                  // hold

        // R7: idle cycles neither count nor vote
        tag = "R7";
        put(-1); step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0);
        put(-1); step(1'b0, 1'b1, 1'b1); put(0); step(1'b0, 1'b0, 1'b0); put(1);

        // R8: verdict stays put across idle cycles and repeated equal results
        tag = "R8";
        group4(1, 1, 1, 1);
        repeat (5) step(1'b0, 1'b0, 1'b1);
        group4(1, 0, 1, 1);

        // R9: reset mid-group discards the partial group
        tag = "R9";
        put(-1); put(-1); put(-1);
        do_reset();
        tag = "R9";
        group4(1, 1, 0, 1);

        // R2 / R6: long mixed stream
        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            else       step(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        tag = "R6";
        repeat (4) step(1'b1, 1'b1, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule